// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block runs the entry into the one non-maskable interrupt of a 32-bit pipelined core, and the return from it. It also owns the stack pointer that both operations use.

When the interrupt line rises, the sequencer latches the request and raises a busy flag. It also stalls instruction fetch, so that the instructions already in flight can retire. Once the pipeline reports that it is empty, the sequencer captures the core's next-PC. It pushes that value onto a descending stack as two 16-bit words, then reads the handler address from two fixed vector words in data memory. The new PC goes back to the fetch stage in a one-cycle load pulse.

An RTI strobe from decode starts the reverse walk. The sequencer pops the two saved words, restores the stack pointer and loads the restored PC. The memory port is a simple synchronous one: a read returns its data on the clock after the address is presented.

Top module: `trap_sequencer`

## Requirements
- R1: A synchronous reset, active high, takes effect on one clock edge. After it, busy and fetch_stall are low, sp_out equals 4095 and any latched request is discarded, so no entry starts once reset is released.
- R2: The interrupt cannot be masked and is caught on a rising edge of irq_in sampled at a clock edge. busy and fetch_stall go high after that edge and stay high through the cycle in which pc_load pulses.
- R3: No stack write and no vector read happens while pipe_idle is low. The sequencer waits for the pipeline to empty for as long as that takes.
- R4: The return address is the value of next_pc in the first cycle in which pipe_idle is high while the sequencer waits. The upper 16 bits are written at address sp_out and the lower 16 bits at sp_out-1. sp_out then decreases by 2.
- R5: The handler PC is assembled from a read of word address 2, which gives bits 15:0, and a read of word address 3, which gives bits 31:16. Read data is taken one clock after its address.
- R6: pc_load is high for exactly one cycle per entry or return, and pc_target carries the new PC in that cycle.
- R7: On an rti_req strobe while the sequencer is idle, bits 15:0 of the PC are read from sp_out+1 and bits 31:16 from sp_out+2. sp_out increases by 2, and the restored value is loaded through pc_load.
- R8: An interrupt edge that arrives during an entry or a return is held. It is serviced right after the current sequence, and busy stays high in between.
- R9: When rti_req and a pending interrupt meet in the idle state, the return runs first and the interrupt entry follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | 1 | Non-maskable interrupt request, caught on a rising edge |
| rti_req | input | 1 | One-cycle strobe from decode for a return from interrupt |
| pipe_idle | input | 1 | High when no instruction remains in flight |
| next_pc | input | 32 | Address of the next instruction the core would fetch |
| mem_rdata | input | 16 | Read data, valid one clock after the address |
| mem_addr | output | 12 | Word address to data memory |
| mem_we | output | 1 | Write enable |
| mem_re | output | 1 | Read enable |
| mem_wdata | output | 16 | Write data |
| busy | output | 1 | Entry or return in progress, or a request pending |
| fetch_stall | output | 1 | Holds instruction fetch |
| pc_load | output | 1 | One-cycle pulse that loads pc_target into the PC |
| pc_target | output | 32 | New PC, valid with pc_load |
| sp_out | output | 12 | Current stack pointer |

## Verification
The first pattern is a single interrupt with the pipeline held busy for several cycles. It separates correct draining from an early push, and it shows the order of the two stack words and of the two vector words. A second edge during an entry, and an RTI strobe that meets a fresh edge, tell a latched, ordered service apart from a dropped or reordered request. Back-to-back returns then unwind a two-deep stack, which checks that the pointer and the address arithmetic are symmetric. A reset in the middle of the drain phase checks that the request is cleared and the sequencer comes back idle.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_VEC_LO,
        ST_VEC_HI,
        ST_VEC_END,
        ST_POP_LO,
        ST_POP_HI,
        ST_POP_END,
        ST_LOAD
    } seq_state_e;

    typedef enum logic [1:0] {
        SP_HOLD,
        SP_PUSH,
        SP_POP
    } sp_op_e;

    // Word address of the low half of the handler vector; high half follows.
    localparam int unsigned VEC_BASE = 2;

    function automatic logic is_mem_phase(seq_state_e s);
        return (s == ST_PUSH_HI) || (s == ST_PUSH_LO) || (s == ST_VEC_LO) ||
               (s == ST_VEC_HI) || (s == ST_POP_LO) || (s == ST_POP_HI);
    endfunction

endpackage

// File: rtl/trap_pending.sv
module trap_pending (
    input  logic clk,
    input  logic rst,
    input  logic irq_in,
    input  logic take,
    output logic pend
);
    logic irq_q;
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            irq_q <= irq_in;
            if (irq_in && !irq_q)
                pend_q <= 1'b1;
            else if (take)
                pend_q <= 1'b0;
        end
    end

    assign pend = pend_q;

    // R1: reset discards a latched request
    p_reset_clears_r1: assert property (@(posedge clk) $past(rst) |-> !pend_q);

    // R2: every rising edge is latched
    p_edge_latched_r2: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq_in) && !$past(rst)) |=> pend_q);

endmodule

// File: rtl/trap_stack_ptr.sv
module trap_stack_ptr
    import trap_seq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  sp_op_e            op,
    output logic [ADDR_W-1:0] sp
);
    localparam logic [ADDR_W-1:0] SP_INIT = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(2);

    logic [ADDR_W-1:0] sp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= SP_INIT;
        end else begin
            case (op)
                SP_PUSH: sp_q <= sp_q - STEP;
                SP_POP:  sp_q <= sp_q + STEP;
                default: sp_q <= sp_q;
            endcase
        end
    end

    assign sp = sp_q;

    // R4 / R7: the pointer only moves in steps of two words
    p_sp_step_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(sp_q)) |->
        ((sp_q == $past(sp_q) - STEP) || (sp_q == $past(sp_q) + STEP)));

endmodule

// File: rtl/trap_fsm.sv
module trap_fsm
    import trap_seq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int WORD_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pend,
    input  logic                rti_req,
    input  logic                pipe_idle,
    input  logic [2*WORD_W-1:0] next_pc,
    input  logic [ADDR_W-1:0]   sp,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic                take,
    output sp_op_e              sp_op,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_we,
    output logic                mem_re,
    output logic [WORD_W-1:0]   mem_wdata,
    output logic                pc_load,
    output logic [2*WORD_W-1:0] pc_target,
    output logic                active
);
    localparam int PC_W = 2 * WORD_W;
    localparam logic [ADDR_W-1:0] VEC_LO_A = ADDR_W'(VEC_BASE);
    localparam logic [ADDR_W-1:0] VEC_HI_A = ADDR_W'(VEC_BASE + 1);

    seq_state_e      state;
    logic [PC_W-1:0] ret_pc;
    logic [PC_W-1:0] tgt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            ret_pc <= '0;
            tgt    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (rti_req)   state <= ST_POP_LO;
                    else if (pend) state <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (pipe_idle) begin
                        ret_pc <= next_pc;
                        state  <= ST_PUSH_HI;
                    end
                end
                ST_PUSH_HI: state <= ST_PUSH_LO;
                ST_PUSH_LO: state <= ST_VEC_LO;
                ST_VEC_LO:  state <= ST_VEC_HI;
                ST_VEC_HI: begin
                    tgt[WORD_W-1:0] <= mem_rdata;
                    state <= ST_VEC_END;
                end
                ST_VEC_END: begin
                    tgt[PC_W-1:WORD_W] <= mem_rdata;
                    state <= ST_LOAD;
                end
                ST_POP_LO: state <= ST_POP_HI;
                ST_POP_HI: begin
                    tgt[WORD_W-1:0] <= mem_rdata;
                    state <= ST_POP_END;
                end
                ST_POP_END: begin
                    tgt[PC_W-1:WORD_W] <= mem_rdata;
                    state <= ST_LOAD;
                end
                ST_LOAD: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_addr  = '0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_wdata = '0;
        sp_op     = SP_HOLD;
        case (state)
            ST_PUSH_HI: begin
                mem_we    = 1'b1;
                mem_addr  = sp;
                mem_wdata = ret_pc[PC_W-1:WORD_W];
            end
            ST_PUSH_LO: begin
                mem_we    = 1'b1;
                mem_addr  = sp - ADDR_W'(1);
                mem_wdata = ret_pc[WORD_W-1:0];
                sp_op     = SP_PUSH;
            end
            ST_VEC_LO: begin
                mem_re   = 1'b1;
                mem_addr = VEC_LO_A;
            end
            ST_VEC_HI: begin
                mem_re   = 1'b1;
                mem_addr = VEC_HI_A;
            end
            ST_POP_LO: begin
                mem_re   = 1'b1;
                mem_addr = sp + ADDR_W'(1);
            end
            ST_POP_HI: begin
                mem_re   = 1'b1;
                mem_addr = sp + ADDR_W'(2);
                sp_op    = SP_POP;
            end
            default: ;
        endcase
    end

    assign take      = (state == ST_IDLE) && !rti_req && pend;
    assign pc_load   = (state == ST_LOAD);
    assign pc_target = tgt;
    assign active    = (state != ST_IDLE);

    // R6: the load pulse lasts one cycle
    p_load_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> !pc_load);

    // R3: no progress out of the drain phase while the pipeline is busy
    p_drain_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRAIN && !pipe_idle) |=> (state == ST_DRAIN));

    // R3: memory is touched only in the access phases
    p_mem_phase_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_we || mem_re) |-> is_mem_phase(state));

endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
    import trap_seq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int WORD_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                irq_in,
    input  logic                rti_req,
    input  logic                pipe_idle,
    input  logic [2*WORD_W-1:0] next_pc,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_we,
    output logic                mem_re,
    output logic [WORD_W-1:0]   mem_wdata,
    output logic                busy,
    output logic                fetch_stall,
    output logic                pc_load,
    output logic [2*WORD_W-1:0] pc_target,
    output logic [ADDR_W-1:0]   sp_out
);
    logic   pend;
    logic   take;
    logic   active;
    sp_op_e sp_op;

    trap_pending u_pend (
        .clk    (clk),
        .rst    (rst),
        .irq_in (irq_in),
        .take   (take),
        .pend   (pend)
    );

    trap_stack_ptr #(.ADDR_W(ADDR_W)) u_sp (
        .clk (clk),
        .rst (rst),
        .op  (sp_op),
        .sp  (sp_out)
    );

    trap_fsm #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .pend      (pend),
        .rti_req   (rti_req),
        .pipe_idle (pipe_idle),
        .next_pc   (next_pc),
        .sp        (sp_out),
        .mem_rdata (mem_rdata),
        .take      (take),
        .sp_op     (sp_op),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_wdata (mem_wdata),
        .pc_load   (pc_load),
        .pc_target (pc_target),
        .active    (active)
    );

    assign busy        = pend || active;
    assign fetch_stall = busy;

    // R2: memory activity only while the sequencer reports busy
    p_mem_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_we || mem_re) |-> busy);

    // R2: the load pulse happens while busy is still high
    p_load_busy_r2: assert property (@(posedge clk) disable iff (rst)
        pc_load |-> (busy && fetch_stall));

endmodule

// File: tb/trap_sequencer_test.sv
module trap_sequencer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_in = 1'b0;
    logic        rti_req = 1'b0;
    logic        pipe_idle = 1'b1;
    logic [31:0] next_pc = '0;
    logic [15:0] mem_rdata;
    logic [11:0] mem_addr;
    logic        mem_we, mem_re;
    logic [15:0] mem_wdata;
    logic        busy, fetch_stall, pc_load;
    logic [31:0] pc_target;
    logic [11:0] sp_out;

    logic [15:0] mem [0:4095];
    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;
    int wr_count = 0;

    localparam logic [31:0] VEC = 32'hABCD_1234;

    always #4 clk = ~clk;

    trap_sequencer uut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .rti_req(rti_req),
        .pipe_idle(pipe_idle), .next_pc(next_pc), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .busy(busy), .fetch_stall(fetch_stall),
        .pc_load(pc_load), .pc_target(pc_target), .sp_out(sp_out)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wr_count <= wr_count + 1;
        end
        mem_rdata <= mem[mem_addr];
        cyc <= cyc + 1;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_load(output logic [31:0] tgt, output logic busy_at);
        int n = 0;
        tgt = '0;
        busy_at = 1'b0;
        while (!pc_load && n < 80) begin
            @(negedge clk);
            n++;
        end
        check(pc_load == 1'b1, "R6 load pulse seen", {31'd0, pc_load}, 32'd1);
        tgt = pc_target;
        busy_at = busy;
        @(negedge clk);
        check(pc_load == 1'b0, "R6 load pulse one cycle", {31'd0, pc_load}, 32'd0);
    endtask

    task automatic pulse_irq();
        irq_in = 1'b1;
        @(negedge clk);
        irq_in = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(busy == 1'b0, "R1 busy after reset", {31'd0, busy}, 32'd0);
        check(fetch_stall == 1'b0, "R1 stall after reset", {31'd0, fetch_stall}, 32'd0);
        check(sp_out == 12'd4095, "R1 sp after reset", {20'd0, sp_out}, 32'd4095);
    endtask

    task automatic t_entry_drain();
        logic [31:0] t;
        logic b;
        int w0;
        next_pc = 32'h0000_0100;
        pipe_idle = 1'b0;
        w0 = wr_count;
        pulse_irq();
        check(busy == 1'b1, "R2 busy after edge", {31'd0, busy}, 32'd1);
        check(fetch_stall == 1'b1, "R2 stall after edge", {31'd0, fetch_stall}, 32'd1);
        repeat (6) @(negedge clk);
        check(wr_count == w0, "R3 no write while draining", wr_count, w0);
        check(mem_re == 1'b0, "R3 no read while draining", {31'd0, mem_re}, 32'd0);
        next_pc = 32'h0000_0100;
        pipe_idle = 1'b1;
        @(negedge clk);
        next_pc = 32'hDEAD_BEEF;
        wait_load(t, b);
        check(t == VEC, "R5 vector from words 2 and 3", t, VEC);
        check(b == 1'b1, "R2 busy during load", {31'd0, b}, 32'd1);
        check(busy == 1'b0, "R2 busy drops after load", {31'd0, busy}, 32'd0);
        check(mem[4095] == 16'h0000, "R4 high half at sp", {16'd0, mem[4095]}, 32'h0000);
        check(mem[4094] == 16'h0100, "R4 low half at sp-1", {16'd0, mem[4094]}, 32'h0100);
        check(sp_out == 12'd4093, "R4 sp minus 2", {20'd0, sp_out}, 32'd4093);
    endtask

    task automatic t_nested();
        logic [31:0] t;
        logic b;
        next_pc = 32'h0000_0200;
        pipe_idle = 1'b1;
        pulse_irq();
        repeat (3) @(negedge clk);
        pulse_irq();
        wait_load(t, b);
        check(t == VEC, "R8 first entry target", t, VEC);
        check(b == 1'b1, "R8 busy held for pending", {31'd0, b}, 32'd1);
        next_pc = 32'h1357_9BDF;
        wait_load(t, b);
        check(t == VEC, "R8 second entry target", t, VEC);
        check(mem[4093] == 16'h0000 && mem[4092] == 16'h0200, "R4 first nested push",
              {mem[4093], mem[4092]}, 32'h0000_0200);
        check(mem[4091] == 16'h1357 && mem[4090] == 16'h9BDF, "R8 second nested push",
              {mem[4091], mem[4090]}, 32'h1357_9BDF);
        check(sp_out == 12'd4089, "R8 sp after two entries", {20'd0, sp_out}, 32'd4089);
    endtask

    task automatic do_rti(input logic [31:0] exp_pc, input logic [11:0] exp_sp);
        logic [31:0] t;
        logic b;
        rti_req = 1'b1;
        @(negedge clk);
        rti_req = 1'b0;
        check(busy == 1'b1, "R7 busy during return", {31'd0, busy}, 32'd1);
        wait_load(t, b);
        check(t == exp_pc, "R7 restored pc", t, exp_pc);
        check(sp_out == exp_sp, "R7 sp plus 2", {20'd0, sp_out}, {20'd0, exp_sp});
    endtask

    task automatic t_priority();
        logic [31:0] t;
        logic b;
        next_pc = 32'h0000_0300;
        irq_in = 1'b1;
        rti_req = 1'b1;
        @(negedge clk);
        irq_in = 1'b0;
        rti_req = 1'b0;
        wait_load(t, b);
        check(t == 32'h0000_0100, "R9 return served first", t, 32'h0000_0100);
        check(sp_out == 12'd4095, "R9 sp after return", {20'd0, sp_out}, 32'd4095);
        check(b == 1'b1, "R9 entry still pending", {31'd0, b}, 32'd1);
        wait_load(t, b);
        check(t == VEC, "R9 entry follows", t, VEC);
        check(mem[4094] == 16'h0300, "R9 pushed pc low half", {16'd0, mem[4094]}, 32'h0300);
        check(sp_out == 12'd4093, "R9 sp after entry", {20'd0, sp_out}, 32'd4093);
    endtask

    task automatic t_reset_mid();
        int w0;
        pipe_idle = 1'b0;
        pulse_irq();
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(busy == 1'b0, "R1 busy cleared mid entry", {31'd0, busy}, 32'd0);
        check(sp_out == 12'd4095, "R1 sp reset mid entry", {20'd0, sp_out}, 32'd4095);
        w0 = wr_count;
        pipe_idle = 1'b1;
        repeat (6) @(negedge clk);
        check(busy == 1'b0 && fetch_stall == 1'b0, "R1 request discarded",
              {31'd0, busy}, 32'd0);
        check(wr_count == w0, "R1 no push after reset", wr_count, w0);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
        mem[2] = VEC[15:0];
        mem[3] = VEC[31:16];
        @(negedge clk);
        t_reset();
        t_entry_drain();
        t_nested();
        do_rti(32'h1357_9BDF, 12'd4091);
        do_rti(32'h0000_0200, 12'd4093);
        t_priority();
        do_rti(32'h0000_0300, 12'd4095);
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        wait (cyc >= 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule